// File: doc/BRIEF.md
# Rounding Interval Timer

This block produces a periodic "interval done" indication from a free-running prescaler whose overflow pulses arrive as a one-cycle `tick` input. Software writes an interval measured in raw oscillator ticks. The timer can only count whole prescaler periods of 4096 ticks, so it rounds the interval up to the next multiple of 4096 and counts that many `tick` pulses. The resulting period is never zero.

When the count completes, a sticky `done` flag is set. The flag stays set until software pulses `clr`. Deciding whether `done` raises an interrupt is left to logic outside the block.

A newly written interval does not restart the countdown that is already running. It is held as the pending period and is loaded at the next expiry, so the first completion after a write can arrive up to one full old period late. The readback port returns the raw value that was last written, with the sign bit forced to zero. It does not return the rounded period.

Top module: `interval_timer`

## Requirements
- R1: After reset, `done` is 0, `rd_data` is 0 and the pending period is one prescaler period, so the first `tick` after reset sets `done`.
- R2: One cycle after a cycle with `wr_en` high, `rd_data` equals `wr_data` with bit 35 cleared. Without `wr_en`, `rd_data` holds its value.
- R3: The pending period in `tick` pulses is bits 34:12 of the written value. One is added when any of bits 11:0 is nonzero.
- R4: If that 23-bit sum is zero, including a carry that wraps to zero when bits 34:12 are all ones, the period becomes one `tick`.
- R5: Only cycles with `tick` high advance the count. The `tick` that completes the running period makes `done` read 1 in the following cycle, and the counter reloads from the pending period in that same cycle.
- R6: A write does not disturb the running countdown. The new period applies from the next expiry onward, and a write in the same cycle as an expiry applies only from the expiry after that.
- R7: `done` stays 1 until a cycle with `clr` high. That cycle clears `done` for the next cycle, unless an expiry occurs in the same cycle.
- R8: When `clr` and an expiry occur in the same cycle, `done` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a new interval |
| wr_data | input | 36 | Interval in oscillator ticks; bit 35 is unused |
| rd_data | output | 36 | Last written interval with bit 35 cleared |
| tick | input | 1 | One-cycle prescaler overflow pulse |
| clr | input | 1 | Clear strobe for the done flag |
| done | output | 1 | Sticky interval-done flag |

## Verification
The assertions assume that `tick` is a single-cycle pulse sampled on the block's clock. They make no assumption about how close together two pulses may be. The stimulus drives `tick` as an arbitrary level each cycle, which also covers back-to-back pulses.

The assertions also assume that `wr_en` and `clr` may coincide with a `tick` in any combination. The directed cases deliberately place a write and a clear on an expiring `tick`. The random phase keeps most programmed intervals to a few prescaler periods, so that many expiries occur within the run.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned IVT_DATA_W = 36;
  localparam int unsigned IVT_PRE_W  = 12;
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned PRE_W  = 12,
  localparam int unsigned CNT_W = DATA_W - 1 - PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  pend_cnt
);
  logic [DATA_W-1:0] rd_q, rd_d;
  logic [CNT_W-1:0]  pend_q, pend_d;
  logic [CNT_W-1:0]  whole, summed, rounded;
  logic              frac;

  // round the raw tick count up to whole prescaler periods
  always_comb begin
    whole   = wr_data[DATA_W-2:PRE_W];
    frac    = |wr_data[PRE_W-1:0];
    summed  = whole + CNT_W'(frac);
    rounded = (summed == '0) ? CNT_W'(1) : summed;
  end

  always_comb begin
    rd_d   = rd_q;
    pend_d = pend_q;
    if (wr_en) begin
      rd_d   = {1'b0, wr_data[DATA_W-2:0]};
      pend_d = rounded;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      pend_q <= CNT_W'(1);
    end else if (wr_en) begin
      rd_q   <= rd_d;
      pend_q <= pend_d;
    end
  end

  assign rd_data  = rd_q;
  assign pend_cnt = pend_q;

  p_pend_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt != '0);
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pend_cnt));
endmodule

// File: rtl/ivt_count.sv
module ivt_count #(
  parameter int unsigned CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] pend_cnt,
  output logic             expire
);
  logic [CNT_W-1:0] left_q, left_d;
  logic             last;

  assign last   = (left_q == CNT_W'(1));
  assign expire = tick && last;

  always_comb begin
    left_d = left_q;
    if (tick) left_d = last ? pend_cnt : left_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    left_q <= CNT_W'(1);
    else if (tick) left_q <= left_d;
  end

  p_left_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    left_q != '0);
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(left_q));
  p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !last) |=> left_q == $past(left_q) - CNT_W'(1));
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> left_q == $past(pend_cnt));
endmodule

// File: rtl/ivt_flag.sv
module ivt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  output logic done
);
  logic done_q, done_d;

  always_comb begin
    done_d = done_q;
    if (clr)    done_d = 1'b0;
    if (expire) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign done = done_q;

  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> done);
  p_expire_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && clr) |=> done);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !expire) |=> !done);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done);
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !expire) |=> !done);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import ivt_pkg::*;
#(
  parameter int unsigned DATA_W = IVT_DATA_W,
  parameter int unsigned PRE_W  = IVT_PRE_W,
  localparam int unsigned CNT_W = DATA_W - 1 - PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick,
  input  logic              clr,
  output logic              done
);
  logic [CNT_W-1:0] pend_cnt;
  logic             expire;

  ivt_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pend_cnt(pend_cnt)
  );

  ivt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pend_cnt(pend_cnt),
    .expire(expire)
  );

  ivt_flag u_flag (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr(clr), .done(done)
  );

  p_expire_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> tick);
  p_rd_sign_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[DATA_W-1] == 1'b0);
endmodule

// File: tb/interval_timer_test.sv
module interval_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data;
  logic        tick = 1'b0;
  logic        clr = 1'b0;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [22:0] m_pend, m_left;
  logic        m_done;
  logic [35:0] m_rd;

  interval_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .clr(clr), .done(done)
  );

  always #2.5 clk = ~clk;

  function automatic logic [22:0] period_of(input logic [35:0] v);
    logic [22:0] s;
    s = v[34:12] + {22'd0, |v[11:0]};
    if (s == 23'd0) s = 23'd1;
    return s;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [35:0] d, input logic t, input logic c);
    logic ex;
    @(negedge clk);
    wr_en = w; wr_data = d; tick = t; clr = c;
    @(posedge clk);
    ex = t && (m_left == 23'd1);
    if (t) m_left = ex ? m_pend : m_left - 23'd1;
    if (w) begin
      m_pend = period_of(d);
      m_rd   = {1'b0, d[34:0]};
    end
    if (c)  m_done = 1'b0;
    if (ex) m_done = 1'b1;
    #1;
    chk("R5 R7 R8 done vs model", {63'd0, done}, {63'd0, m_done});
    chk("R2 readback vs model", {28'd0, rd_data}, {28'd0, m_rd});
  endtask

  task automatic count_ticks(output int n);
    n = 0;
    do begin
      step(1'b0, '0, 1'b1, 1'b0);
      n++;
    end while (!done && n < 64);
  endtask

  // write v, drain the old period, then measure the new one
  task automatic measure(input logic [35:0] v, input int exp_n, input string tag);
    int n;
    step(1'b0, '0, 1'b0, 1'b1);
    step(1'b1, v, 1'b0, 1'b0);
    count_ticks(n);
    step(1'b0, '0, 1'b0, 1'b1);
    count_ticks(n);
    chk(tag, 64'(n), 64'(exp_n));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    m_pend = 23'd1; m_left = 23'd1; m_done = 1'b0; m_rd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset done", {63'd0, done}, 64'd0);
    chk("R1 reset readback", {28'd0, rd_data}, 64'd0);
    step(1'b0, '0, 1'b1, 1'b0);
    chk("R1 first tick expires", {63'd0, done}, 64'd1);

    measure(36'h0_0000_3000, 3, "R3 exact multiple");
    measure(36'h0_0000_3005, 4, "R3 low bits round up");
    measure(36'h0_0000_0800, 1, "R3 fraction only");
    measure(36'h0_0000_0000, 1, "R4 zero forced to one");
    measure(36'h7_FFFF_F001, 1, "R4 carry wraps to one");
    measure(36'h8_0000_2000, 2, "R2 sign bit ignored");
    chk("R2 sign cleared on readback", {28'd0, rd_data}, 64'h0_0000_2000);

    // R6: write mid-countdown does not disturb the running period
    measure(36'h0_0000_5000, 5, "R6 setup period");
    step(1'b0, '0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b1, 1'b0);
    step(1'b0, '0, 1'b1, 1'b0);
    step(1'b1, 36'h0_0000_1000, 1'b0, 1'b0);
    count_ticks(n);
    chk("R6 running period kept", 64'(n), 64'd3);
    step(1'b0, '0, 1'b0, 1'b1);
    count_ticks(n);
    chk("R6 new period after expiry", 64'(n), 64'd1);

    // R6: write on the expiring tick applies one expiry later
    step(1'b0, '0, 1'b0, 1'b1);
    step(1'b1, 36'h0_0000_4000, 1'b1, 1'b0);
    chk("R6 expiry with write", {63'd0, done}, 64'd1);
    step(1'b0, '0, 1'b0, 1'b1);
    count_ticks(n);
    chk("R6 old period reloaded", 64'(n), 64'd1);
    step(1'b0, '0, 1'b0, 1'b1);
    count_ticks(n);
    chk("R6 new period later", 64'(n), 64'd4);

    // R7 sticky and clear; R8 clear vs expiry
    measure(36'h0_0000_1000, 1, "R8 setup period");
    repeat (4) step(1'b0, '0, 1'b0, 1'b0);
    chk("R7 flag sticky", {63'd0, done}, 64'd1);
    step(1'b0, '0, 1'b1, 1'b1);
    chk("R8 expiry beats clear while set", {63'd0, done}, 64'd1);
    step(1'b0, '0, 1'b0, 1'b1);
    chk("R7 clear strobe", {63'd0, done}, 64'd0);
    step(1'b0, '0, 1'b1, 1'b1);
    chk("R8 expiry beats clear while clear", {63'd0, done}, 64'd1);

    // R5: idle cycles do not advance the count
    measure(36'h0_0000_2000, 2, "R5 setup period");
    step(1'b0, '0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b1, 1'b0);
    repeat (6) step(1'b0, '0, 1'b0, 1'b0);
    chk("R5 no expiry without tick", {63'd0, done}, 64'd0);
    step(1'b0, '0, 1'b1, 1'b0);
    chk("R5 expiry on completing tick", {63'd0, done}, 64'd1);

    // random phase, model-checked every cycle
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [35:0] d;
      logic        w, t, c;
      d = {$urandom(), $urandom()};
      if ($urandom_range(0, 9) != 0) d[34:12] = 23'($urandom_range(0, 6));
      if ($urandom_range(0, 1) == 0) d[11:0] = '0;
      w = ($urandom_range(0, 29) == 0);
      t = ($urandom_range(0, 1) == 0);
      c = ($urandom_range(0, 7) == 0);
      step(w, d, t, c);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule